// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block controls a port of general-purpose lines (32 by default) through a simple word-addressed register bus. Every line has one owner at a time: either the controller itself or one of four peripheral functions, named A to D. Two select bit-planes pick the function for each line. Software changes ownership, output enable, output data, the direct-write mask and open-drain mode through paired set and clear ports. Writing a 1 to a bit acts on that line, and a 0 leaves it unchanged.

When the controller owns a line, its output-enable and data bits drive the pad. When a peripheral owns the line, the selected function's enable and value drive the pad. All peripheral inputs receive the raw pad level whatever the ownership. A masked direct write to the data register lets some lines rise and others fall in a single access. In open-drain mode a line is pulled low actively and released otherwise.

Writes take effect at the clock edge that samples them. Pad outputs and read data are combinational from the stored state.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset the owner plane reads all ones, meaning every line is owned by the controller. Output enable, output data, write mask, open-drain and both select planes read 0, and pad_oe is 0 on every line.
- R2: Word addresses are: 0 owner-set, 1 owner-clear, 2 owner status, 3 enable-set, 4 enable-clear, 5 enable status, 6 data-set, 7 data-clear, 8 data (read, or masked direct write), 9 mask-set, 10 mask-clear, 11 mask status, 12 open-drain-set, 13 open-drain-clear, 14 open-drain status, 15 select plane low, 16 select plane high, 17 pin level. On a set port a 1 bit sets the status bit; on a clear port a 1 bit clears it; a 0 bit leaves the line unchanged. Each status reads back at its own address.
- R3: On a controller-owned line that is not in open-drain mode, pad_oe equals the enable status bit and pad_out equals the data bit.
- R4: A 1 written to owner-clear gives the line to its selected peripheral, and a 1 written to owner-set returns it to the controller. Owner status 1 means the controller owns the line.
- R5: For a peripheral-owned line, {select high bit, select low bit} = 00, 01, 10 or 11 selects function A, B, C or D respectively. The function's per_oe and per_do bits for that line drive pad_oe and pad_out. The select planes are written whole at addresses 15 and 16.
- R6: per_di always equals pad_in, whatever the ownership or mode of each line.
- R7: Enable and data writes update the stored bits even while a peripheral owns the line. The stored values drive the pad as soon as the controller takes the line back.
- R8: A write to address 8 updates only the data bits whose mask bit is 1, and all of them change at the same edge. Bits whose mask bit is 0 keep their value.
- R9: In open-drain mode pad_out is 0 and pad_oe is the owner's enable AND NOT the owner's value, so a 1 level releases the line.
- R10: Address 17 reads the current pad_in levels, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | N_LINES | Write data, one bit per line |
| bus_rdata | output | N_LINES | Read data for bus_addr |
| per_do | input | 4 x N_LINES | Output values of functions A..D (index 0..3) |
| per_oe | input | 4 x N_LINES | Output enables of functions A..D (index 0..3) |
| per_di | output | N_LINES | Pad level routed to every function |
| pad_in | input | N_LINES | Level sensed on each pad |
| pad_out | output | N_LINES | Value driven on each pad |
| pad_oe | output | N_LINES | Drive enable of each pad |

## Verification
The masked direct data write is the one access where setting and clearing land on the same edge. The bench arranges eight controller-driven lines with half of them high and all of them in the mask, then writes the inverted pattern. It samples pad_out once before and once after that single edge and expects every line to have flipped, while an unmasked line keeps its stored level. Ownership hand-over and open-drain gating act in the same cycle as the selected peripheral's drive, and these are judged the same way at the pads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_AW  = 5;
    localparam int GPIO_NFN = 4;

    typedef enum logic [GPIO_AW-1:0] {
        ADR_OWN_SET  = 5'd0,
        ADR_OWN_CLR  = 5'd1,
        ADR_OWN_STAT = 5'd2,
        ADR_OE_SET   = 5'd3,
        ADR_OE_CLR   = 5'd4,
        ADR_OE_STAT  = 5'd5,
        ADR_DAT_SET  = 5'd6,
        ADR_DAT_CLR  = 5'd7,
        ADR_DAT      = 5'd8,
        ADR_MSK_SET  = 5'd9,
        ADR_MSK_CLR  = 5'd10,
        ADR_MSK_STAT = 5'd11,
        ADR_OD_SET   = 5'd12,
        ADR_OD_CLR   = 5'd13,
        ADR_OD_STAT  = 5'd14,
        ADR_SEL_LO   = 5'd15,
        ADR_SEL_HI   = 5'd16,
        ADR_PIN      = 5'd17
    } gpio_adr_e;

    // function chosen by {high plane, low plane}
    typedef enum logic [1:0] {
        FN_A = 2'b00,
        FN_B = 2'b01,
        FN_C = 2'b10,
        FN_D = 2'b11
    } gpio_fn_e;

    typedef struct packed {
        logic own_set;
        logic own_clr;
        logic oe_set;
        logic oe_clr;
        logic dat_set;
        logic dat_clr;
        logic dat_wr;
        logic msk_set;
        logic msk_clr;
        logic od_set;
        logic od_clr;
        logic sel_lo_wr;
        logic sel_hi_wr;
    } gpio_strb_t;

endpackage

// File: rtl/gpio_bitplane.sv
module gpio_bitplane #(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         dir_we,
    input  logic [W-1:0] dir_mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (set_we) begin
            q <= q | wdata;
        end else if (clr_we) begin
            q <= q & ~wdata;
        end else if (dir_we) begin
            q <= (q & ~dir_mask) | (wdata & dir_mask);
        end
    end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                        [N-1:0] own_q,
    input  logic                        [N-1:0] oe_q,
    input  logic                        [N-1:0] dat_q,
    input  logic                        [N-1:0] od_q,
    input  logic                        [N-1:0] sel_lo_q,
    input  logic                        [N-1:0] sel_hi_q,
    input  logic [GPIO_NFN-1:0]         [N-1:0] per_do,
    input  logic [GPIO_NFN-1:0]         [N-1:0] per_oe,
    output logic                        [N-1:0] pad_out,
    output logic                        [N-1:0] pad_oe
);

    for (genvar i = 0; i < N; i++) begin : g_line
        gpio_fn_e fn;
        logic     val;
        logic     en;

        always_comb begin
            fn = gpio_fn_e'({sel_hi_q[i], sel_lo_q[i]});
            if (own_q[i]) begin
                val = dat_q[i];
                en  = oe_q[i];
            end else begin
                val = per_do[fn][i];
                en  = per_oe[fn][i];
            end
            if (od_q[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = en & ~val;
            end else begin
                pad_out[i] = val;
                pad_oe[i]  = en;
            end
        end
    end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [GPIO_AW-1:0] addr,
    input  logic [N-1:0]       own_q,
    input  logic [N-1:0]       oe_q,
    input  logic [N-1:0]       dat_q,
    input  logic [N-1:0]       msk_q,
    input  logic [N-1:0]       od_q,
    input  logic [N-1:0]       sel_lo_q,
    input  logic [N-1:0]       sel_hi_q,
    input  logic [N-1:0]       pin_lvl,
    output logic [N-1:0]       rdata
);

    always_comb begin
        unique case (gpio_adr_e'(addr))
            ADR_OWN_STAT: rdata = own_q;
            ADR_OE_STAT:  rdata = oe_q;
            ADR_DAT:      rdata = dat_q;
            ADR_MSK_STAT: rdata = msk_q;
            ADR_OD_STAT:  rdata = od_q;
            ADR_SEL_LO:   rdata = sel_lo_q;
            ADR_SEL_HI:   rdata = sel_hi_q;
            ADR_PIN:      rdata = pin_lvl;
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
    import gpio_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_we,
    input  logic [GPIO_AW-1:0]                bus_addr,
    input  logic [N_LINES-1:0]                bus_wdata,
    output logic [N_LINES-1:0]                bus_rdata,
    input  logic [GPIO_NFN-1:0][N_LINES-1:0]  per_do,
    input  logic [GPIO_NFN-1:0][N_LINES-1:0]  per_oe,
    output logic [N_LINES-1:0]                per_di,
    input  logic [N_LINES-1:0]                pad_in,
    output logic [N_LINES-1:0]                pad_out,
    output logic [N_LINES-1:0]                pad_oe
);

    localparam logic [N_LINES-1:0] ALL_ONE  = {N_LINES{1'b1}};
    localparam logic [N_LINES-1:0] ALL_ZERO = '0;

    gpio_strb_t         strb;
    logic [N_LINES-1:0] own_q, oe_q, dat_q, msk_q, od_q, sel_lo_q, sel_hi_q;

    always_comb begin
        strb = '0;
        if (bus_we) begin
            unique case (gpio_adr_e'(bus_addr))
                ADR_OWN_SET: strb.own_set   = 1'b1;
                ADR_OWN_CLR: strb.own_clr   = 1'b1;
                ADR_OE_SET:  strb.oe_set    = 1'b1;
                ADR_OE_CLR:  strb.oe_clr    = 1'b1;
                ADR_DAT_SET: strb.dat_set   = 1'b1;
                ADR_DAT_CLR: strb.dat_clr   = 1'b1;
                ADR_DAT:     strb.dat_wr    = 1'b1;
                ADR_MSK_SET: strb.msk_set   = 1'b1;
                ADR_MSK_CLR: strb.msk_clr   = 1'b1;
                ADR_OD_SET:  strb.od_set    = 1'b1;
                ADR_OD_CLR:  strb.od_clr    = 1'b1;
                ADR_SEL_LO:  strb.sel_lo_wr = 1'b1;
                ADR_SEL_HI:  strb.sel_hi_wr = 1'b1;
                default:     ;
            endcase
        end
    end

    gpio_bitplane #(.W(N_LINES), .RST_VAL(ALL_ONE)) u_own (
        .clk(clk), .rst_n(rst_n), .set_we(strb.own_set), .clr_we(strb.own_clr),
        .dir_we(1'b0), .dir_mask(ALL_ZERO), .wdata(bus_wdata), .q(own_q));

    gpio_bitplane #(.W(N_LINES), .RST_VAL(ALL_ZERO)) u_oe (
        .clk(clk), .rst_n(rst_n), .set_we(strb.oe_set), .clr_we(strb.oe_clr),
        .dir_we(1'b0), .dir_mask(ALL_ZERO), .wdata(bus_wdata), .q(oe_q));

    gpio_bitplane #(.W(N_LINES), .RST_VAL(ALL_ZERO)) u_dat (
        .clk(clk), .rst_n(rst_n), .set_we(strb.dat_set), .clr_we(strb.dat_clr),
        .dir_we(strb.dat_wr), .dir_mask(msk_q), .wdata(bus_wdata), .q(dat_q));

    gpio_bitplane #(.W(N_LINES), .RST_VAL(ALL_ZERO)) u_msk (
        .clk(clk), .rst_n(rst_n), .set_we(strb.msk_set), .clr_we(strb.msk_clr),
        .dir_we(1'b0), .dir_mask(ALL_ZERO), .wdata(bus_wdata), .q(msk_q));

    gpio_bitplane #(.W(N_LINES), .RST_VAL(ALL_ZERO)) u_od (
        .clk(clk), .rst_n(rst_n), .set_we(strb.od_set), .clr_we(strb.od_clr),
        .dir_we(1'b0), .dir_mask(ALL_ZERO), .wdata(bus_wdata), .q(od_q));

    gpio_bitplane #(.W(N_LINES), .RST_VAL(ALL_ZERO)) u_sel_lo (
        .clk(clk), .rst_n(rst_n), .set_we(1'b0), .clr_we(1'b0),
        .dir_we(strb.sel_lo_wr), .dir_mask(ALL_ONE), .wdata(bus_wdata), .q(sel_lo_q));

    gpio_bitplane #(.W(N_LINES), .RST_VAL(ALL_ZERO)) u_sel_hi (
        .clk(clk), .rst_n(rst_n), .set_we(1'b0), .clr_we(1'b0),
        .dir_we(strb.sel_hi_wr), .dir_mask(ALL_ONE), .wdata(bus_wdata), .q(sel_hi_q));

    gpio_pin_mux #(.N(N_LINES)) u_pin_mux (
        .own_q(own_q), .oe_q(oe_q), .dat_q(dat_q), .od_q(od_q),
        .sel_lo_q(sel_lo_q), .sel_hi_q(sel_hi_q),
        .per_do(per_do), .per_oe(per_oe),
        .pad_out(pad_out), .pad_oe(pad_oe));

    gpio_rd_mux #(.N(N_LINES)) u_rd_mux (
        .addr(bus_addr), .own_q(own_q), .oe_q(oe_q), .dat_q(dat_q),
        .msk_q(msk_q), .od_q(od_q), .sel_lo_q(sel_lo_q), .sel_hi_q(sel_hi_q),
        .pin_lvl(pad_in), .rdata(bus_rdata));

    // every function sees the raw pad level
    assign per_di = pad_in;

endmodule

// File: rtl/gpio_mux_ctrl_chk.sv
module gpio_mux_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [GPIO_AW-1:0] bus_addr,
    input logic [N_LINES-1:0] bus_wdata,
    input logic [N_LINES-1:0] own_q,
    input logic [N_LINES-1:0] oe_q,
    input logic [N_LINES-1:0] dat_q,
    input logic [N_LINES-1:0] msk_q,
    input logic [N_LINES-1:0] od_q,
    input logic [N_LINES-1:0] sel_lo_q,
    input logic [N_LINES-1:0] pad_out,
    input logic [N_LINES-1:0] pad_oe
);

    AST_OE_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_OE_SET) |=> (oe_q == ($past(oe_q) | $past(bus_wdata)))); // R2

    AST_CTRL_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_q & ~od_q & (pad_oe ^ oe_q)) == '0)); // R3

    AST_OWN_CLR_HANDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_OWN_CLR) |=> ((own_q & $past(bus_wdata)) == '0)); // R4

    AST_SEL_LO_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_SEL_LO) |=> (sel_lo_q == $past(bus_wdata))); // R5

    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_DAT) |=>
            ((dat_q & ~$past(msk_q)) == ($past(dat_q) & ~$past(msk_q)))); // R8

    AST_OD_RELEASES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((od_q & own_q & dat_q & pad_oe) == '0)); // R9

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((od_q & pad_out) == '0)); // R9

endmodule

bind gpio_mux_ctrl gpio_mux_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .own_q(own_q), .oe_q(oe_q), .dat_q(dat_q),
    .msk_q(msk_q), .od_q(od_q), .sel_lo_q(sel_lo_q),
    .pad_out(pad_out), .pad_oe(pad_oe));

// File: tb/gpio_mux_ctrl_tb.sv
module gpio_mux_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 32;
    localparam int WD_CYCLES  = 20000;

    localparam logic [4:0] A_OWN_SET = 5'd0,  A_OWN_CLR = 5'd1,  A_OWN_STAT = 5'd2;
    localparam logic [4:0] A_OE_SET  = 5'd3,  A_OE_CLR  = 5'd4,  A_OE_STAT  = 5'd5;
    localparam logic [4:0] A_DAT_SET = 5'd6,  A_DAT_CLR = 5'd7,  A_DAT      = 5'd8;
    localparam logic [4:0] A_MSK_SET = 5'd9,  A_MSK_CLR = 5'd10, A_MSK_STAT = 5'd11;
    localparam logic [4:0] A_OD_SET  = 5'd12, A_OD_CLR  = 5'd13, A_OD_STAT  = 5'd14;
    localparam logic [4:0] A_SEL_LO  = 5'd15, A_SEL_HI  = 5'd16, A_PIN      = 5'd17;

    typedef struct packed {
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{A_OE_SET,  32'h0000_00FF, A_OE_STAT,  32'h0000_00FF, 4'd2},  // R2
        '{A_OE_CLR,  32'h0000_000F, A_OE_STAT,  32'h0000_00F0, 4'd2},  // R2
        '{A_DAT_SET, 32'hA5A5_0000, A_DAT,      32'hA5A5_0000, 4'd2},  // R2
        '{A_DAT_CLR, 32'h8000_0000, A_DAT,      32'h25A5_0000, 4'd2},  // R2
        '{A_MSK_SET, 32'h0000_FFFF, A_MSK_STAT, 32'h0000_FFFF, 4'd2},  // R2
        '{A_DAT,     32'hFFFF_1234, A_DAT,      32'h25A5_1234, 4'd8},  // R8
        '{A_MSK_CLR, 32'h0000_FF00, A_MSK_STAT, 32'h0000_00FF, 4'd2},  // R2
        '{A_DAT,     32'h0000_0000, A_DAT,      32'h25A5_1200, 4'd8},  // R8
        '{A_OWN_CLR, 32'h0000_0003, A_OWN_STAT, 32'hFFFF_FFFC, 4'd4},  // R4
        '{A_OWN_SET, 32'h0000_0001, A_OWN_STAT, 32'hFFFF_FFFD, 4'd4},  // R4
        '{A_SEL_LO,  32'h0000_0002, A_SEL_LO,   32'h0000_0002, 4'd5},  // R5
        '{A_PIN,     32'h0000_1234, A_PIN,      32'hCAFE_F00D, 4'd10}, // R10
        '{A_OD_SET,  32'h0000_0001, A_OD_STAT,  32'h0000_0001, 4'd2}   // R2
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_we = 1'b0;
    logic [4:0]          bus_addr = '0;
    logic [N-1:0]        bus_wdata = '0;
    logic [N-1:0]        bus_rdata;
    logic [3:0][N-1:0]   per_do = '0;
    logic [3:0][N-1:0]   per_oe = '0;
    logic [N-1:0]        per_di;
    logic [N-1:0]        pad_in = 32'hCAFE_F00D;
    logic [N-1:0]        pad_out;
    logic [N-1:0]        pad_oe;

    int total = 0;
    int bad   = 0;

    gpio_mux_ctrl #(.N_LINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_do(per_do),
        .per_oe(per_oe), .per_di(per_di), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD_CYCLES, WD_CYCLES);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        do_reset();

        // R1 reset state
        rd(A_OWN_STAT, r); chk("R1 owner", r, 32'hFFFF_FFFF);
        rd(A_OE_STAT, r);  chk("R1 enable", r, 32'h0);
        rd(A_DAT, r);      chk("R1 data", r, 32'h0);
        rd(A_MSK_STAT, r); chk("R1 mask", r, 32'h0);
        rd(A_OD_STAT, r);  chk("R1 opendrain", r, 32'h0);
        rd(A_SEL_LO, r);   chk("R1 sel_lo", r, 32'h0);
        rd(A_SEL_HI, r);   chk("R1 sel_hi", r, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);

        // table walk: write, then read back
        for (int k = 0; k < NV; k++) begin
            wr(VEC[k].wa, VEC[k].wd);
            rd(VEC[k].ra, r);
            chk($sformatf("R%0d vec%0d", VEC[k].req, k), r, VEC[k].exp);
        end

        do_reset();

        // R3 controller drive
        wr(A_OE_SET, 32'h1);
        wr(A_DAT_SET, 32'h1);
        chk("R3 pad_oe", pad_oe & 32'hF, 32'h1);
        chk("R3 pad_out", pad_out & 32'hF, 32'h1);

        // R4/R5 hand lines 0..3 to A,B,C,D
        for (int k = 0; k < 4; k++) begin
            per_oe[k] = 32'h1 << k;
            per_do[k] = 32'h1 << k;
        end
        wr(A_SEL_LO, 32'hA);
        wr(A_SEL_HI, 32'hC);
        wr(A_OWN_CLR, 32'hF);
        chk("R4 R5 pad_oe by function", pad_oe & 32'hF, 32'hF);
        chk("R5 pad_out by function", pad_out & 32'hF, 32'hF);
        for (int k = 0; k < 4; k++) begin
            per_oe[k] = ~(32'h1 << k);
            per_do[k] = ~(32'h1 << k);
        end
        #1;
        chk("R5 other functions ignored oe", pad_oe & 32'hF, 32'h0);
        chk("R5 other functions ignored out", pad_out & 32'hF, 32'h0);

        // R6 input routing
        pad_in = 32'h0F0F_3C3C;
        #1;
        chk("R6 per_di", per_di, 32'h0F0F_3C3C);

        // R7 preset while peripheral owns lines 0 and 1
        wr(A_DAT_CLR, 32'h1);
        wr(A_OE_SET, 32'h2);
        chk("R7 peripheral keeps pad", pad_oe & 32'h3, 32'h0);
        wr(A_OWN_SET, 32'h3);
        chk("R7 preset oe applies", pad_oe & 32'h3, 32'h3);
        chk("R7 preset data applies", pad_out & 32'h3, 32'h0);

        // R9 open drain, controller line 0
        wr(A_OD_SET, 32'h1);
        chk("R9 drive low oe", pad_oe & 32'h1, 32'h1);
        chk("R9 drive low out", pad_out & 32'h1, 32'h0);
        wr(A_DAT_SET, 32'h1);
        chk("R9 release on high", pad_oe & 32'h1, 32'h0);
        chk("R9 out held low", pad_out & 32'h1, 32'h0);
        // R9 open drain, line 3 on function D
        per_oe[3] = 32'hFFFF_FFFF;
        per_do[3] = 32'hFFFF_FFFF;
        wr(A_OD_SET, 32'h8);
        chk("R9 function high released", pad_oe & 32'h8, 32'h0);
        per_do[3] = 32'h0;
        #1;
        chk("R9 function low driven", pad_oe & 32'h8, 32'h8);
        chk("R9 function out low", pad_out & 32'h8, 32'h0);

        // R8 rise and fall at one edge
        wr(A_OE_SET, 32'h0000_FF00);
        wr(A_DAT_SET, 32'h0000_0F00);
        wr(A_MSK_SET, 32'h0000_FF00);
        chk("R8 before write", (pad_out >> 8) & 32'hFF, 32'h0F);
        wr(A_DAT, 32'h0000_F000);
        chk("R8 after one write", (pad_out >> 8) & 32'hFF, 32'hF0);
        rd(A_DAT, r);
        chk("R8 unmasked bit kept", r & 32'h1, 32'h1);

        // R10 pin register write has no effect on other state
        wr(A_PIN, 32'hFFFF_FFFF);
        rd(A_OD_STAT, r);
        chk("R10 state untouched", r, 32'h9);
        rd(A_PIN, r);
        chk("R10 pin level", r, 32'h0F0F_3C3C);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule